// File: doc/BRIEF.md
# Peripheral Register Block with UART Port and Interrupt Status

This block sits on a simple 32-bit load/store bus and answers a handful of fixed addresses. Through them a processor reaches a byte-wide UART data port, an interrupt mask, an interrupt status word, a process identifier, a read-only page address captured on a translation fault, and a write-only window of translation entries. The UART is abstracted: a received byte arrives as a one-cycle valid with data, a transmitted byte leaves as a one-cycle strobe with data, and a level input reports that the transmitter can take another byte.

The status word gathers the UART events, the transmit-ready level, one tap of a free-running counter in both polarities, and a translation fault flag. A single interrupt request is raised while any status bit is also enabled in the mask. Two bus accesses have side effects: reading the UART data address drops the byte-available flag, and writing anywhere in the translation-entry window drops the fault flag. Hardware events win over those side effects when both land in the same cycle.

Top module: `periph_regs`

## Requirements
- R1: A bus write to 0x20000000 raises `tx_strobe` for exactly the following cycle, with `tx_byte` equal to bits 7:0 of the written word.
- R2: `rx_valid` loads `rx_byte` into a holding register; a bus read of 0x20000000 returns that byte (zero-extended) on `bus_rdata` one cycle after the request, and a byte arriving in the same cycle as the read is returned only by the next read.
- R3: Status bit 0 is set in the cycle after `rx_valid` and cleared in the cycle after a read of 0x20000000; when both happen in one cycle the bit stays set.
- R4: Status bit 1 always equals the `tx_ready` input.
- R5: A counter reset to zero advances every cycle; status bit 3 equals its bit `CNT_TAP` and status bit 2 is the inverse of it.
- R6: The mask register at 0x20000010 reads back what was written; a write to the status register at 0x20000020 loads every status bit except bits 1, 2 and 3, which stay live.
- R7: `irq` is high exactly while the bitwise AND of the status word and the mask is nonzero, following register updates in the same cycle they take effect.
- R8: A `fault_valid` pulse sets status bit 9 and captures `fault_addr` with its low 12 bits cleared; 0x20000090 returns that page address and ignores writes.
- R9: A write to any address from 0x200000A0 up to 0x200000A0 + 8*`TLB_ENTRIES` - 1 clears status bit 9; a fault in the same cycle keeps it set, and writes just past the window leave it alone.
- R10: The process-ID register at 0x20000080 reads back the full written word.
- R11: Writes to 0x20000070 change nothing; reads of 0x20000070, of the translation window and of any other unmapped address return zero.
- R12: After reset the mask, status (apart from bits 1 and 2), process ID, fault page, read data and `tx_strobe` are all zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can accept a byte |
| tx_strobe | output | 1 | One-cycle pulse carrying a byte to send |
| tx_byte | output | 8 | Byte to send |
| fault_valid | input | 1 | Translation fault this cycle |
| fault_addr | input | 32 | Faulting address |
| irq | output | 1 | Masked interrupt request |

## Verification
Every registered result is due one cycle after its stimulus: read data, the transmit strobe and each status change appear after the edge that samples the request or event, and `irq` follows in that same cycle because it is derived without a register from mask and status. The bench drives inputs on the falling edge, lets one rising edge pass, and compares on the following falling edge; a read pushes its expected word into a queue and a monitor pops it exactly one edge later. Collision cases (byte arrival during a data read, fault during a window write) are driven in a single cycle so the priority is seen in the next one.

// File: rtl/periph_pkg.sv
package periph_pkg;

  localparam int unsigned ADDR_W = 32;

  localparam logic [ADDR_W-1:0] A_UART  = 32'h2000_0000;
  localparam logic [ADDR_W-1:0] A_MASK  = 32'h2000_0010;
  localparam logic [ADDR_W-1:0] A_STAT  = 32'h2000_0020;
  localparam logic [ADDR_W-1:0] A_CFG   = 32'h2000_0070;
  localparam logic [ADDR_W-1:0] A_PID   = 32'h2000_0080;
  localparam logic [ADDR_W-1:0] A_FAULT = 32'h2000_0090;
  localparam logic [ADDR_W-1:0] A_TLB   = 32'h2000_00A0;

  localparam int unsigned TLB_STRIDE = 8;
  localparam int unsigned PAGE_BITS  = 12;

  localparam int unsigned B_RXAV  = 0;
  localparam int unsigned B_TXRDY = 1;
  localparam int unsigned B_TAPN  = 2;
  localparam int unsigned B_TAP   = 3;
  localparam int unsigned B_FAULT = 9;

  typedef struct packed {
    logic uart;
    logic mask;
    logic stat;
    logic cfg;
    logic pid;
    logic fault;
    logic tlb;
  } hit_t;

endpackage

// File: rtl/periph_decode.sv
module periph_decode
  import periph_pkg::*;
#(
  parameter int unsigned TLB_ENTRIES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);

  localparam logic [ADDR_W-1:0] TLB_END =
    A_TLB + ADDR_W'(TLB_ENTRIES * TLB_STRIDE);

  always_comb begin
    hit       = '0;
    hit.uart  = (addr == A_UART);
    hit.mask  = (addr == A_MASK);
    hit.stat  = (addr == A_STAT);
    hit.cfg   = (addr == A_CFG);
    hit.pid   = (addr == A_PID);
    hit.fault = (addr == A_FAULT);
    hit.tlb   = (addr >= A_TLB) && (addr < TLB_END);
  end

endmodule

// File: rtl/periph_free_counter.sv
module periph_free_counter #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CNT_TAP = 18
) (
  input  logic clk,
  input  logic rst_n,
  output logic tap
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tap = cnt_q[CNT_TAP];

endmodule

// File: rtl/periph_uart_port.sv
module periph_uart_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       tx_strobe,
  output logic [7:0] tx_byte,
  output logic [7:0] rx_hold
);

  logic       strobe_d;
  logic [7:0] txb_q, txb_d;
  logic [7:0] hold_q, hold_d;

  always_comb begin
    strobe_d = wr_en;
    txb_d    = wr_en ? wr_byte : txb_q;
    hold_d   = rx_valid ? rx_byte : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_strobe <= 1'b0;
      txb_q     <= '0;
      hold_q    <= '0;
    end else begin
      tx_strobe <= strobe_d;
      if (wr_en)    txb_q  <= txb_d;
      if (rx_valid) hold_q <= hold_d;
    end
  end

  assign tx_byte = txb_q;
  assign rx_hold = hold_q;

endmodule

// File: rtl/periph_status.sv
module periph_status
  import periph_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_set,
  input  logic              rx_clr,
  input  logic              fault_set,
  input  logic              fault_clr,
  input  logic              tx_ready,
  input  logic              tap,
  output logic [DATA_W-1:0] status_word,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq
);

  logic [DATA_W-1:0] stat_q, stat_d;
  logic [DATA_W-1:0] mask_d;
  logic              stat_en;

  always_comb begin
    stat_en = wr_stat | rx_set | rx_clr | fault_set | fault_clr;
    stat_d  = wr_stat ? wdata : stat_q;
    if (rx_clr)    stat_d[B_RXAV]  = 1'b0;
    if (fault_clr) stat_d[B_FAULT] = 1'b0;
    if (rx_set)    stat_d[B_RXAV]  = 1'b1;
    if (fault_set) stat_d[B_FAULT] = 1'b1;
    stat_d[B_TXRDY] = 1'b0;
    stat_d[B_TAPN]  = 1'b0;
    stat_d[B_TAP]   = 1'b0;
    mask_d = wr_mask ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (wr_mask) mask_q <= mask_d;
    end
  end

  always_comb begin
    status_word          = stat_q;
    status_word[B_TXRDY] = tx_ready;
    status_word[B_TAPN]  = ~tap;
    status_word[B_TAP]   = tap;
    irq = |(status_word & mask_q);
  end

endmodule

// File: rtl/periph_regs.sv
module periph_regs
  import periph_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned CNT_TAP     = 18,
  parameter int unsigned TLB_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [31:0]       bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_ready,
  output logic              tx_strobe,
  output logic [7:0]        tx_byte,
  input  logic              fault_valid,
  input  logic [31:0]       fault_addr,
  output logic              irq
);

  localparam logic [31:0] PAGE_MASK = ~((32'd1 << PAGE_BITS) - 32'd1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  hit_t hit;
  logic rd_en, wr_en;
  logic [DATA_W-1:0] status_word, mask_q;
  logic [7:0]        rx_hold;
  logic              tap;

  assign rd_en = bus_sel & ~bus_we;
  assign wr_en = bus_sel &  bus_we;

  periph_decode #(.TLB_ENTRIES(TLB_ENTRIES)) u_decode (
    .addr (bus_addr),
    .hit  (hit)
  );

  periph_free_counter #(.CNT_W(CNT_W), .CNT_TAP(CNT_TAP)) u_counter (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tap   (tap)
  );

  periph_uart_port u_uart (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en & hit.uart),
    .wr_byte   (bus_wdata[7:0]),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte),
    .rx_hold   (rx_hold)
  );

  periph_status #(.DATA_W(DATA_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_stat     (wr_en & hit.stat),
    .wr_mask     (wr_en & hit.mask),
    .wdata       (bus_wdata),
    .rx_set      (rx_valid),
    .rx_clr      (rd_en & hit.uart),
    .fault_set   (fault_valid),
    .fault_clr   (wr_en & hit.tlb),
    .tx_ready    (tx_ready),
    .tap         (tap),
    .status_word (status_word),
    .mask_q      (mask_q),
    .irq         (irq)
  );

  // process identifier and captured fault page
  logic [DATA_W-1:0] pid_q, pid_d;
  logic [31:0]       page_q, page_d;
  logic              pid_en;

  always_comb begin
    pid_en = wr_en & hit.pid;
    pid_d  = pid_en ? bus_wdata : pid_q;
    page_d = fault_valid ? (fault_addr & PAGE_MASK) : page_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pid_q  <= '0;
      page_q <= '0;
    end else begin
      if (pid_en)      pid_q  <= pid_d;
      if (fault_valid) page_q <= page_d;
    end
  end

  // registered read data
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    unique case (1'b1)
      hit.uart:  rdata_d = DATA_W'(rx_hold);
      hit.mask:  rdata_d = mask_q;
      hit.stat:  rdata_d = status_word;
      hit.pid:   rdata_d = pid_q;
      hit.fault: rdata_d = DATA_W'(page_q);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (rd_en)   rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/periph_regs_chk.sv
module periph_regs_chk
  import periph_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TLB_ENTRIES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [31:0]       bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rx_valid,
  input logic              tx_ready,
  input logic              fault_valid,
  input logic              tx_strobe,
  input logic [7:0]        tx_byte,
  input logic [DATA_W-1:0] status_word,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq
);

  localparam logic [31:0] WIN_END = A_TLB + 32'(TLB_ENTRIES * TLB_STRIDE);

  logic uart_wr, uart_rd, win_wr;
  assign uart_wr = bus_sel &  bus_we & (bus_addr == A_UART);
  assign uart_rd = bus_sel & ~bus_we & (bus_addr == A_UART);
  assign win_wr  = bus_sel &  bus_we & (bus_addr >= A_TLB) & (bus_addr < WIN_END);

  p_tx_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    uart_wr |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));

  p_tx_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_wr |=> !tx_strobe);

  p_rx_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> status_word[B_RXAV]);

  p_rx_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uart_rd && !rx_valid) |=> !status_word[B_RXAV]);

  p_tx_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[B_TXRDY] == tx_ready);

  p_tap_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[B_TAPN] != status_word[B_TAP]);

  p_irq_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mask_q[B_RXAV] && !(bus_sel && bus_we && bus_addr == A_MASK)) |=> irq);

  p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> status_word[B_FAULT]);

  p_fault_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !fault_valid) |=> !status_word[B_FAULT]);

endmodule

bind periph_regs periph_regs_chk #(
  .DATA_W      (DATA_W),
  .TLB_ENTRIES (TLB_ENTRIES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rx_valid    (rx_valid),
  .tx_ready    (tx_ready),
  .fault_valid (fault_valid),
  .tx_strobe   (tx_strobe),
  .tx_byte     (tx_byte),
  .status_word (status_word),
  .mask_q      (mask_q),
  .irq         (irq)
);

// File: tb/periph_regs_bench.sv
module periph_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [31:0] NOCNT = ~32'h0000_000C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_ready = 1'b1;
  logic        tx_strobe;
  logic [7:0]  tx_byte;
  logic        fault_valid = 1'b0;
  logic [31:0] fault_addr = '0;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_regs #(.CNT_TAP(6)) u_periph_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_ready(tx_ready),
    .tx_strobe(tx_strobe), .tx_byte(tx_byte),
    .fault_valid(fault_valid), .fault_addr(fault_addr), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  logic [31:0] care_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: a read issued at one edge is compared one edge later
  logic rd_issued = 1'b0;
  always @(posedge clk) rd_issued <= bus_sel && !bus_we;

  always @(negedge clk) begin
    if (rd_issued) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: unexpected read data 0x%08h expected none", bus_rdata);
      end else begin
        logic [31:0] e, c;
        string t;
        e = exp_q.pop_front();
        c = care_q.pop_front();
        t = tag_q.pop_front();
        chk(t, bus_rdata & c, e & c);
      end
    end
  end

  task automatic bus_wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [31:0] a, logic [31:0] e, logic [31:0] c, string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); care_q.push_back(c); tag_q.push_back(t);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx_pulse(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic fault_pulse(logic [31:0] a);
    @(negedge clk);
    fault_valid = 1'b1; fault_addr = a;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seen_hi, seen_lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    chk("R12 irq", {31'b0, irq}, 32'd0);
    chk("R12 tx_strobe", {31'b0, tx_strobe}, 32'd0);
    chk("R12 rdata", bus_rdata, 32'd0);
    bus_rd(32'h2000_0020, 32'h6, '1, "R12 R5 status after reset");
    bus_rd(32'h2000_0010, 32'h0, '1, "R12 mask");
    bus_rd(32'h2000_0080, 32'h0, '1, "R12 pid");
    bus_rd(32'h2000_0090, 32'h0, '1, "R12 fault page");

    // R1 transmit
    bus_wr(32'h2000_0000, 32'h1234_56A5);
    chk("R1 strobe", {31'b0, tx_strobe}, 32'd1);
    chk("R1 byte", {24'b0, tx_byte}, 32'hA5);
    @(negedge clk);
    chk("R1 single pulse", {31'b0, tx_strobe}, 32'd0);

    // R2 R3 receive and clear on read
    rx_pulse(8'h3C);
    bus_rd(32'h2000_0020, 32'h3, NOCNT, "R3 set");
    bus_rd(32'h2000_0000, 32'h3C, '1, "R2 data");
    bus_rd(32'h2000_0020, 32'h2, NOCNT, "R3 clear");

    // R3 arrival in the same cycle as the data read
    rx_pulse(8'h11);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 32'h2000_0000;
    rx_valid = 1'b1; rx_byte = 8'h22;
    exp_q.push_back(32'h11); care_q.push_back('1); tag_q.push_back("R2 old byte on collision");
    @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0;
    bus_rd(32'h2000_0020, 32'h3, NOCNT, "R3 set wins");
    bus_rd(32'h2000_0000, 32'h22, '1, "R2 new byte");
    bus_rd(32'h2000_0020, 32'h2, NOCNT, "R3 cleared");

    // R4 transmit ready
    @(negedge clk); tx_ready = 1'b0;
    bus_rd(32'h2000_0020, 32'h0, NOCNT, "R4 ready low");
    @(negedge clk); tx_ready = 1'b1;

    // R6 R7 mask, status write, irq
    bus_wr(32'h2000_0010, 32'h2);
    chk("R7 irq from ready", {31'b0, irq}, 32'd1);
    bus_wr(32'h2000_0010, 32'h201);
    bus_rd(32'h2000_0010, 32'h201, '1, "R6 mask");
    chk("R7 irq idle", {31'b0, irq}, 32'd0);
    rx_pulse(8'h5A);
    chk("R7 irq rx", {31'b0, irq}, 32'd1);
    bus_rd(32'h2000_0000, 32'h5A, '1, "R2 data 5A");
    chk("R7 irq after read", {31'b0, irq}, 32'd0);
    bus_wr(32'h2000_0020, 32'hABCD_000F);
    chk("R7 irq status write", {31'b0, irq}, 32'd1);
    bus_rd(32'h2000_0020, 32'hABCD_0003, NOCNT, "R6 status load");
    bus_wr(32'h2000_0020, 32'h0);
    chk("R7 irq cleared", {31'b0, irq}, 32'd0);

    // R8 fault capture
    fault_pulse(32'h1234_5678);
    chk("R8 irq fault", {31'b0, irq}, 32'd1);
    bus_rd(32'h2000_0090, 32'h1234_5000, '1, "R8 page");
    bus_rd(32'h2000_0020, 32'h202, NOCNT, "R8 status");
    bus_wr(32'h2000_0090, 32'hDEAD_BEEF);
    bus_rd(32'h2000_0090, 32'h1234_5000, '1, "R8 read-only");

    // R9 window writes
    bus_wr(32'h2000_00B8, 32'h0);
    chk("R9 irq after window write", {31'b0, irq}, 32'd0);
    bus_rd(32'h2000_0020, 32'h2, NOCNT, "R9 cleared by last entry");
    fault_pulse(32'h0000_1FFF);
    bus_rd(32'h2000_0090, 32'h0000_1000, '1, "R8 second page");
    bus_wr(32'h2000_00C0, 32'h0);
    bus_rd(32'h2000_0020, 32'h202, NOCNT, "R9 outside window");
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 32'h2000_00A0; bus_wdata = 32'h0;
    fault_valid = 1'b1; fault_addr = 32'h0000_2000;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; fault_valid = 1'b0;
    bus_rd(32'h2000_0020, 32'h202, NOCNT, "R9 fault wins");
    bus_wr(32'h2000_00A4, 32'h0);
    bus_rd(32'h2000_0020, 32'h2, NOCNT, "R9 cleared");

    // R10 process id
    bus_wr(32'h2000_0080, 32'h55);
    bus_rd(32'h2000_0080, 32'h55, '1, "R10 pid");
    bus_wr(32'h2000_0080, 32'hFFFF_FFFF);
    bus_rd(32'h2000_0080, 32'hFFFF_FFFF, '1, "R10 pid full");

    // R11 config and unmapped
    bus_wr(32'h2000_0070, 32'hFFFF_FFFF);
    bus_rd(32'h2000_0070, 32'h0, '1, "R11 config");
    bus_rd(32'h2000_0040, 32'h0, '1, "R11 unmapped");
    bus_rd(32'h2000_00A0, 32'h0, '1, "R11 window read");
    bus_rd(32'h2000_0010, 32'h201, '1, "R11 mask kept");
    bus_rd(32'h2000_0080, 32'hFFFF_FFFF, '1, "R11 pid kept");
    bus_rd(32'h2000_0020, 32'h2, NOCNT, "R11 status kept");

    // R5 counter tap
    seen_hi = 0; seen_lo = 0;
    for (int i = 0; i < 80; i++) begin
      bus_rd(32'h2000_0020, 32'h2, NOCNT, "R5 other bits");
      if (bus_rdata[3] == bus_rdata[2]) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 polarity: actual 0x%08h expected bits 2/3 opposite", bus_rdata);
      end
      if (bus_rdata[3]) seen_hi++; else seen_lo++;
    end
    chk("R5 tap high seen", {31'b0, seen_hi > 0}, 32'd1);
    chk("R5 tap low seen", {31'b0, seen_lo > 0}, 32'd1);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule